// File: doc/BRIEF.md
# TDM Audio Serial Slave Port

This block is the serial side of a multichannel audio converter. It runs entirely on an externally supplied bit clock and frame sync, and it never drives either one. Each frame is 256 bit clocks long and is split into eight 32-bit slots. The first six slots carry six audio channels in each direction. The incoming line (`sdin`) is deserialised into six parallel playback words. Six parallel capture words (`tx_data`) are serialised onto `sdout` in the same slots.

Each sample occupies the top of its slot, most significant bit first. Its valid width is 16, 18, 20 or 24 bits and is chosen per frame. The transmit words and the width are taken into shadow storage when a frame starts. The six received words appear together with a one-cycle strobe as soon as the last bit of the sixth slot has been captured. A frame sync that arrives at the wrong count realigns the slot counter and raises a sticky error flag.

Top module: `tdm_slave_port`

## Requirements
- R1: While `rst_n` is low and afterwards until the first frame sync, `sdout`, `rx_valid` and `frame_err` are 0 and `rx_data` is all zero.
- R2: A frame starts at the bit-clock rising edge where `fs` is first seen high after being low. The next rising edge captures bit 0 of the frame. Bit p of the frame belongs to slot p/32 at position p%32, and position 0 is the slot's MSB. Channel c (0..5) uses slot c, and its first bit lands in `rx_data[c][23]`.
- R3: `len_sel` encodes the sample width as 0=16, 1=18, 2=20 and 3=24 bits. Received bits at slot positions at or beyond the width are ignored, and the matching low bits of `rx_data[c]` read 0. Slots 6 and 7 never reach `rx_data`.
- R4: `rx_valid` is high for exactly one bit-clock period. That period follows the rising edge that captures frame bit 191 (the last bit of slot 5). All six `rx_data` words update at that same edge and hold steady at all other times.
- R5: Frame bit p is driven on `sdout` from the falling edge before the rising edge that captures it. It equals `tx_data[p/32][23-p%32]` when p/32 < 6 and p%32 is below the width. Otherwise it is 0.
- R6: Bit 0 of a frame (MSB of channel 0) is driven right after the frame-start rising edge, before the following falling edge.
- R7: `tx_data` and `len_sel` are sampled only at the frame-start edge. Changes during a frame do not affect `sdout` or `rx_data` for that frame.
- R8: A frame start that does not fall exactly 256 bit clocks after the previous one restarts the count at bit 0 and sets `frame_err`. `frame_err` stays set until reset. Correctly spaced frame syncs never set it.
- R9: Before the first frame sync after reset, `sdout` stays 0 and `rx_valid` never pulses, whatever `sdin` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | External bit clock, 256 periods per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | External frame sync; its rising edge marks a frame start |
| sdin | input | 1 | Serial playback data, sampled on rising `sclk` |
| sdout | output | 1 | Serial capture data, launched on falling `sclk` |
| len_sel | input | 2 | Sample width select, 0=16, 1=18, 2=20, 3=24 bits |
| tx_data | input | 6x24 | Parallel capture words, one per channel |
| rx_data | output | 6x24 | Parallel playback words, left-justified |
| rx_valid | output | 1 | One-cycle strobe when a new set of `rx_data` is ready |
| frame_err | output | 1 | Sticky flag for a misplaced frame sync |

## Verification
Random slot contents are sent under each of the four width codes. This separates a correct width decode from an off-by-one in the cut-off, because the bits just past the width are random and must read 0. A frame of all-ones capture words at the 16-bit width shows that the unused positions of `sdout` are zero-filled rather than left over from earlier data. One frame changes `tx_data` and `len_sel` halfway through, which shows whether the shadow copy is really frame-aligned. A shortened frame followed by normal ones shows that a misplaced sync raises the error flag, while the realigned frames after it still decode correctly.

// File: rtl/tdm_slave_port.sv
`timescale 1ns/1ps
module tdm_slave_port #(
  parameter int CHANNELS = 6,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8
) (
  input  logic                               sclk,
  input  logic                               rst_n,
  input  logic                               fs,
  input  logic                               sdin,
  output logic                               sdout,
  input  logic [1:0]                         len_sel,
  input  logic [CHANNELS-1:0][SAMPLE_W-1:0]  tx_data,
  output logic [CHANNELS-1:0][SAMPLE_W-1:0]  rx_data,
  output logic                               rx_valid,
  output logic                               frame_err
);
  localparam int FRAME    = SLOT_W * SLOTS;
  localparam int POS_W    = $clog2(FRAME);
  localparam int BIT_W    = $clog2(SLOT_W);
  localparam int IDX_W    = POS_W - BIT_W;
  localparam int LEN_W    = BIT_W + 1;
  localparam int LAST_POS = CHANNELS * SLOT_W - 1;

  function automatic logic [LEN_W-1:0] len_of(input logic [1:0] s);
    case (s)
      2'd0:    return LEN_W'(16);
      2'd1:    return LEN_W'(18);
      2'd2:    return LEN_W'(20);
      default: return LEN_W'(24);
    endcase
  endfunction

  logic                              fs_q, locked, tx_q, tx_bit;
  logic [POS_W-1:0]                  pos;
  logic [LEN_W-1:0]                  len_q;
  logic [CHANNELS-1:0][SAMPLE_W-1:0] shadow, work, work_nxt;
  logic [SAMPLE_W-1:0]               word_nxt;

  wire             fs_rise = fs & ~fs_q;
  wire [IDX_W-1:0] slot    = pos[POS_W-1:BIT_W];
  wire [BIT_W-1:0] bidx    = pos[BIT_W-1:0];
  wire             in_chan = int'(slot) < CHANNELS;
  wire             in_len  = {1'b0, bidx} < len_q;
  wire [POS_W-1:0] pos_inc = (pos == POS_W'(FRAME - 1)) ? '0 : pos + 1'b1;

  always_comb begin
    word_nxt = (bidx == '0) ? '0 : work[slot];
    if (in_len) word_nxt[SAMPLE_W-1-int'(bidx)] = sdin;
    work_nxt = work;
    if (in_chan) work_nxt[slot] = word_nxt;
  end

  assign tx_bit = (in_chan && in_len) ? shadow[slot][SAMPLE_W-1-int'(bidx)] : 1'b0;
  assign sdout  = (locked && pos == '0) ? tx_bit : tx_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      locked    <= 1'b0;
      frame_err <= 1'b0;
      rx_valid  <= 1'b0;
      pos       <= '0;
      len_q     <= len_of(2'd3);
      shadow    <= '0;
      work      <= '0;
      rx_data   <= '0;
    end else begin
      fs_q     <= fs;
      rx_valid <= 1'b0;
      if (fs_rise) begin
        pos    <= '0;
        locked <= 1'b1;
        shadow <= tx_data;
        len_q  <= len_of(len_sel);
        if (locked && pos != POS_W'(FRAME - 1)) frame_err <= 1'b1;
      end else begin
        pos <= pos_inc;
      end
      if (locked) begin
        work <= work_nxt;
        if (pos == POS_W'(LAST_POS)) begin
          rx_data  <= work_nxt;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_bit;
  end
endmodule

// File: rtl/tdm_slave_port_chk.sv
`timescale 1ns/1ps
module tdm_slave_port_chk #(
  parameter int DATA_W = 144
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              sdout,
  input logic              locked,
  input logic              fs_rise,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] shadow
);
  // R4
  valid_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  rx_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);

  // R8
  err_sticky_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R7
  shadow_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !fs_rise |=> $stable(shadow));

  // R9
  idle_low_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !locked |-> (!sdout && !rx_valid));
endmodule

bind tdm_slave_port tdm_slave_port_chk #(.DATA_W(CHANNELS * SAMPLE_W)) u_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .frame_err (frame_err),
  .sdout     (sdout),
  .locked    (locked),
  .fs_rise   (fs_rise),
  .rx_data   (rx_data),
  .shadow    (shadow)
);

// File: tb/test_tdm_slave_port.sv
`timescale 1ns/1ps
module test_tdm_slave_port;
  localparam int CH = 6;
  localparam int SW = 24;
  typedef logic [CH-1:0][SW-1:0] frame_t;

  logic       sclk = 1'b0, rst_n = 1'b0, fs = 1'b0, sdin = 1'b0;
  logic [1:0] len_sel = 2'd3;
  frame_t     tx_data = '0;
  frame_t     rx_data;
  logic       sdout, rx_valid, frame_err;

  int     checks = 0, errors = 0;
  bit     done = 1'b0;
  frame_t rxq[$];

  always #2 sclk = ~sclk;

  tdm_slave_port i_tdm_slave_port (
    .sclk(sclk), .rst_n(rst_n), .fs(fs), .sdin(sdin), .sdout(sdout),
    .len_sel(len_sel), .tx_data(tx_data), .rx_data(rx_data),
    .rx_valid(rx_valid), .frame_err(frame_err)
  );

  function automatic int width_of(logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // monitor: pops the expected word set on each strobe
  always @(posedge sclk) begin
    frame_t e;
    #1;
    if (rst_n && rx_valid && !done) begin
      if (rxq.size() == 0)
        check(1'b0, $sformatf("R4 R9 unexpected strobe actual=%h expected=none", rx_data));
      else begin
        e = rxq.pop_front();
        check(rx_data == e, $sformatf("R2 R3 rx words actual=%h expected=%h", rx_data, e));
      end
    end
  end

  function automatic frame_t rand_words(bit msb);
    frame_t w;
    for (int c = 0; c < CH; c++) w[c] = SW'($urandom);
    w[0][SW-1] = msb;
    return w;
  endfunction

  task automatic run_frame(input frame_t words, input logic [1:0] sel,
                           input int flen, input bit perturb, input bit push);
    logic [7:0][31:0] slots;
    frame_t e;
    int ln, bad;
    ln = width_of(sel);
    for (int s = 0; s < 8; s++) slots[s] = $urandom;
    for (int c = 0; c < CH; c++)
      for (int b = 0; b < SW; b++)
        e[c][SW-1-b] = (b < ln) ? slots[c][31-b] : 1'b0;
    if (push) rxq.push_back(e);
    @(negedge sclk);
    fs = 1'b1; sdin = 1'($urandom); tx_data = words; len_sel = sel;
    @(posedge sclk);
    #0.5;
    check(sdout === words[0][SW-1],
          $sformatf("R6 early MSB actual=%b expected=%b", sdout, words[0][SW-1]));
    bad = 0;
    for (int j = 1; j < flen; j++) begin
      int p, sl, b;
      logic expb;
      p = j - 1; sl = p / 32; b = p % 32;
      @(negedge sclk);
      if (j == 16) fs = 1'b0;
      sdin = slots[sl][31-b];
      if (perturb && j == 60) begin
        tx_data = ~words;
        len_sel = sel + 2'd1;
      end
      #1.5;
      expb = (sl < CH && b < ln) ? words[sl][SW-1-b] : 1'b0;
      if (sdout !== expb) bad++;
    end
    check(bad == 0, $sformatf("R5%s tx bit mismatches actual=%0d expected=0",
                              perturb ? " R7" : "", bad));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    frame_t ones;
    repeat (3) @(negedge sclk);
    #1.5;
    check(sdout === 1'b0 && rx_valid === 1'b0,
          $sformatf("R1 reset outputs actual=%b%b expected=00", sdout, rx_valid));
    check(frame_err === 1'b0, $sformatf("R1 reset error flag actual=%b expected=0", frame_err));
    check(rx_data === '0, $sformatf("R1 reset rx words actual=%h expected=0", rx_data));
    @(negedge sclk);
    rst_n = 1'b1; sdin = 1'b1;
    bad = 0;
    repeat (300) begin
      @(negedge sclk);
      sdin = 1'($urandom);
      #1.5;
      if (sdout !== 1'b0) bad++;
    end
    check(bad == 0, $sformatf("R9 idle sdout high count actual=%0d expected=0", bad));

    run_frame(rand_words(1'b1), 2'd3, 256, 1'b0, 1'b1);
    run_frame(rand_words(1'b0), 2'd0, 256, 1'b0, 1'b1);
    run_frame(rand_words(1'b1), 2'd1, 256, 1'b0, 1'b1);
    run_frame(rand_words(1'b1), 2'd2, 256, 1'b0, 1'b1);
    for (int c = 0; c < CH; c++) ones[c] = '1;
    run_frame(ones, 2'd0, 256, 1'b0, 1'b1);
    check(frame_err === 1'b0, $sformatf("R8 regular syncs flag actual=%b expected=0", frame_err));

    run_frame(rand_words(1'b1), 2'd2, 256, 1'b1, 1'b1);
    run_frame(rand_words(1'b1), 2'd3, 100, 1'b0, 1'b0);
    check(frame_err === 1'b0, $sformatf("R8 flag before early sync actual=%b expected=0", frame_err));
    run_frame(rand_words(1'b1), 2'd3, 256, 1'b0, 1'b1);
    check(frame_err === 1'b1, $sformatf("R8 early sync flag actual=%b expected=1", frame_err));
    run_frame(rand_words(1'b0), 2'd1, 256, 1'b0, 1'b1);
    check(frame_err === 1'b1, $sformatf("R8 sticky flag actual=%b expected=1", frame_err));

    repeat (5) @(negedge sclk);
    check(rxq.size() == 0, $sformatf("R4 missing strobes actual=%0d expected=0", rxq.size()));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule